// File: doc/BRIEF.md
# SIMD Execution Mask Controller

This block is the scalar control slice of a wide SIMD machine. It keeps the lane-enable mask that predicates every vector instruction, a vector condition mask filled by per-lane compares, a scalar condition flag, a small file of saved masks and the program counter. Decoded scalar mask operations arrive one per cycle. The controller applies them to these registers and drives the current mask to the vector lanes.

Divergent if/else is built from plain mask arithmetic. A compare fills the condition mask. The live mask is saved into a slot. The "then" side runs under the AND of the condition and the live mask. The "else" side runs under the saved mask with the live lanes cleared. A final move restores the saved mask. Two skip branches let a section be jumped over when either the condition mask or the live mask is empty. Every register update takes effect on the clock edge after issue, and the next instruction sees the new values.

Top module: `simd_mask_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `exec_mask` all ones, `vcc_mask` zero, `pc` zero and `scc` zero, whatever the other inputs are.
- R2: Opcode 1 (compare) loads `vcc_mask` with `cmp_result` AND `exec_mask`, so lanes that are switched off read 0. `exec_mask` and `scc` are unchanged.
- R3: Opcode 2 (save) writes the current `exec_mask` into slot `sdst` of the mask file. No output other than `pc` changes. The saved value is visible through a later restore.
- R4: Opcode 3 (enter then-side) sets `exec_mask` to `vcc_mask` AND `exec_mask`.
- R5: Opcode 4 (enter else-side) sets `exec_mask` to slot `ssrc` AND NOT the current `exec_mask`.
- R6: Opcode 5 (restore) copies slot `ssrc` into `exec_mask` and leaves `scc` unchanged.
- R7: Opcodes 3 and 4 set `scc` to 1 when the new `exec_mask` is nonzero and to 0 otherwise. No other opcode changes `scc`.
- R8: Opcode 6 loads `pc` with `br_target` when `vcc_mask` is zero, and otherwise advances `pc` by one. The masks are unchanged.
- R9: Opcode 7 loads `pc` with `br_target` when `exec_mask` is zero, and otherwise advances `pc` by one. The masks are unchanged.
- R10: With `issue_valid` low, `exec_mask`, `vcc_mask`, `pc` and `scc` all hold.
- R11: Opcode 0 and the unassigned opcodes 8 to 15 only advance `pc` by one.
- R12: `pc` advances modulo 2^PC_W, so the value after all ones is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 4 | Decoded scalar mask operation |
| sdst | input | SEL_W | Mask file slot written by save |
| ssrc | input | SEL_W | Mask file slot read by else and restore |
| br_target | input | PC_W | Target of the skip branches |
| cmp_result | input | LANES | Raw per-lane compare outcome |
| exec_mask | output | LANES | Lane-enable mask driven to the vector lanes |
| vcc_mask | output | LANES | Vector condition mask |
| pc | output | PC_W | Program counter (address of the next instruction) |
| scc | output | 1 | Scalar condition flag |

## Verification
The properties assume that `opcode`, `br_target` and the slot selectors carry known values whenever `issue_valid` is high. They also assume that `ssrc` names a slot that was written earlier. Nothing is checked about the slot contents themselves. The stimulus meets these assumptions in three ways. It drives every input on the falling edge. It writes an all-ones slot right after the first reset, before any else or restore. It reads only slots that the current sweep step has just written. Inputs that arrive while `issue_valid` is low or `rst` is high are deliberately random-looking, because those cycles must have no effect.

// File: rtl/mask_ctrl_pkg.sv
package mask_ctrl_pkg;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_VCMP      = 4'd1,
    OP_SAVE      = 4'd2,
    OP_AND_IF    = 4'd3,
    OP_ANDN_ELSE = 4'd4,
    OP_RESTORE   = 4'd5,
    OP_BR_VCCZ   = 4'd6,
    OP_BR_EXECZ  = 4'd7
  } mop_e;

  typedef struct packed {
    logic ld_exec;
    logic ld_vcc;
    logic ld_scc;
    logic wr_slot;
  } mask_we_t;

  function automatic mask_we_t decode_we(input logic [3:0] op);
    mask_we_t w;
    w = '0;
    case (op)
      OP_VCMP:      w.ld_vcc  = 1'b1;
      OP_SAVE:      w.wr_slot = 1'b1;
      OP_AND_IF,
      OP_ANDN_ELSE: begin
        w.ld_exec = 1'b1;
        w.ld_scc  = 1'b1;
      end
      OP_RESTORE:   w.ld_exec = 1'b1;
      default:      w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mask_slot_file.sv
// Small file of saved masks. The write is synchronous and the read is combinational,
// so it maps to distributed (LUT) RAM and a restore completes in one cycle.
module mask_slot_file #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mask_alu.sv
// Per-lane mask arithmetic: gated compare, then-side AND, else-side AND-NOT.
module mask_alu
  import mask_ctrl_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic [3:0]       op,
  input  logic [LANES-1:0] exec_q,
  input  logic [LANES-1:0] vcc_q,
  input  logic [LANES-1:0] slot_val,
  input  logic [LANES-1:0] cmp_raw,
  output logic [LANES-1:0] exec_d,
  output logic [LANES-1:0] vcc_d,
  output logic             scc_d
);

  logic [LANES-1:0] cmp_gated;
  logic [LANES-1:0] then_m;
  logic [LANES-1:0] else_m;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign cmp_gated[i] = cmp_raw[i] & exec_q[i];
    assign then_m[i]    = vcc_q[i] & exec_q[i];
    assign else_m[i]    = slot_val[i] & ~exec_q[i];
  end

  always_comb begin
    exec_d = exec_q;
    case (op)
      OP_AND_IF:    exec_d = then_m;
      OP_ANDN_ELSE: exec_d = else_m;
      OP_RESTORE:   exec_d = slot_val;
      default:      exec_d = exec_q;
    endcase
  end

  assign vcc_d = cmp_gated;
  assign scc_d = |exec_d;

endmodule

// File: rtl/mask_branch.sv
// Next-PC selection for the two skip branches.
module mask_branch
  import mask_ctrl_pkg::*;
#(
  parameter int LANES = 64,
  parameter int PC_W  = 16
) (
  input  logic [3:0]       op,
  input  logic [LANES-1:0] exec_q,
  input  logic [LANES-1:0] vcc_q,
  input  logic [PC_W-1:0]  pc_q,
  input  logic [PC_W-1:0]  target,
  output logic [PC_W-1:0]  pc_d
);

  logic vcc_empty;
  logic exec_empty;
  logic taken;

  assign vcc_empty  = (vcc_q == '0);
  assign exec_empty = (exec_q == '0);

  always_comb begin
    case (op)
      OP_BR_VCCZ:  taken = vcc_empty;
      OP_BR_EXECZ: taken = exec_empty;
      default:     taken = 1'b0;
    endcase
  end

  assign pc_d = taken ? target : pc_q + PC_W'(1);

endmodule

// File: rtl/simd_mask_ctrl.sv
module simd_mask_ctrl
  import mask_ctrl_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int NSREG  = 8,
  parameter int PC_W   = 16,
  localparam int SEL_W = (NSREG > 1) ? $clog2(NSREG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic [3:0]       opcode,
  input  logic [SEL_W-1:0] sdst,
  input  logic [SEL_W-1:0] ssrc,
  input  logic [PC_W-1:0]  br_target,
  input  logic [LANES-1:0] cmp_result,
  output logic [LANES-1:0] exec_mask,
  output logic [LANES-1:0] vcc_mask,
  output logic [PC_W-1:0]  pc,
  output logic             scc
);

  mask_we_t         we;
  logic [LANES-1:0] slot_val;
  logic [LANES-1:0] exec_d;
  logic [LANES-1:0] vcc_d;
  logic             scc_d;
  logic [PC_W-1:0]  pc_d;

  assign we = decode_we(opcode);

  mask_slot_file #(.W(LANES), .DEPTH(NSREG)) u_slots (
    .clk   (clk),
    .we    (issue_valid & we.wr_slot & ~rst),
    .waddr (sdst),
    .wdata (exec_mask),
    .raddr (ssrc),
    .rdata (slot_val)
  );

  mask_alu #(.LANES(LANES)) u_alu (
    .op       (opcode),
    .exec_q   (exec_mask),
    .vcc_q    (vcc_mask),
    .slot_val (slot_val),
    .cmp_raw  (cmp_result),
    .exec_d   (exec_d),
    .vcc_d    (vcc_d),
    .scc_d    (scc_d)
  );

  mask_branch #(.LANES(LANES), .PC_W(PC_W)) u_br (
    .op     (opcode),
    .exec_q (exec_mask),
    .vcc_q  (vcc_mask),
    .pc_q   (pc),
    .target (br_target),
    .pc_d   (pc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_mask <= {LANES{1'b1}};
      vcc_mask  <= '0;
      pc        <= '0;
      scc       <= 1'b0;
    end else if (issue_valid) begin
      if (we.ld_exec) exec_mask <= exec_d;
      if (we.ld_vcc)  vcc_mask  <= vcc_d;
      if (we.ld_scc)  scc       <= scc_d;
      pc <= pc_d;
    end
  end

endmodule

// File: rtl/simd_mask_ctrl_chk.sv
module simd_mask_ctrl_chk
  import mask_ctrl_pkg::*;
#(
  parameter int LANES = 64,
  parameter int PC_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_valid,
  input logic [3:0]       opcode,
  input logic [PC_W-1:0]  br_target,
  input logic [LANES-1:0] exec_mask,
  input logic [LANES-1:0] vcc_mask,
  input logic [PC_W-1:0]  pc,
  input logic             scc
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (exec_mask == {LANES{1'b1}} && vcc_mask == '0 && pc == '0 && !scc));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> ($stable(exec_mask) && $stable(vcc_mask) && $stable(pc) && $stable(scc)));

  // R2
  vcmp_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opcode == OP_VCMP) |=> ((vcc_mask & ~$past(exec_mask)) == '0 && $stable(exec_mask)));

  // R4
  then_narrows_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opcode == OP_AND_IF) |=> ((exec_mask & ~$past(exec_mask)) == '0));

  // R7
  scc_follows_exec_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (opcode == OP_AND_IF || opcode == OP_ANDN_ELSE)) |=> (scc == (exec_mask != '0)));

  // R8
  vccz_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opcode == OP_BR_VCCZ && vcc_mask == '0) |=> (pc == $past(br_target)));

  // R9
  execz_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opcode == OP_BR_EXECZ) |=> ($stable(exec_mask) && $stable(vcc_mask)));

  // R5
  else_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opcode == OP_ANDN_ELSE) |=> ((exec_mask & $past(exec_mask)) == '0));

endmodule

bind simd_mask_ctrl simd_mask_ctrl_chk #(.LANES(LANES), .PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .opcode      (opcode),
  .br_target   (br_target),
  .exec_mask   (exec_mask),
  .vcc_mask    (vcc_mask),
  .pc          (pc),
  .scc         (scc)
);

// File: tb/simd_mask_ctrl_bench.sv
module simd_mask_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int NSREG = 4;
  localparam int PC_W  = 16;
  localparam int SEL_W = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             issue_valid = 1'b0;
  logic [3:0]       opcode = '0;
  logic [SEL_W-1:0] sdst = '0;
  logic [SEL_W-1:0] ssrc = '0;
  logic [PC_W-1:0]  br_target = '0;
  logic [LANES-1:0] cmp_result = '0;
  logic [LANES-1:0] exec_mask;
  logic [LANES-1:0] vcc_mask;
  logic [PC_W-1:0]  pc;
  logic             scc;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [LANES-1:0] m_exec, m_vcc;
  logic [PC_W-1:0]  m_pc;
  logic             m_scc;
  logic [LANES-1:0] m_slot [NSREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_mask_ctrl #(.LANES(LANES), .NSREG(NSREG), .PC_W(PC_W)) u_simd_mask_ctrl (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .opcode(opcode),
    .sdst(sdst), .ssrc(ssrc), .br_target(br_target), .cmp_result(cmp_result),
    .exec_mask(exec_mask), .vcc_mask(vcc_mask), .pc(pc), .scc(scc)
  );

  task automatic check(input string tag);
    nchk++;
    if (exec_mask !== m_exec || vcc_mask !== m_vcc || pc !== m_pc || scc !== m_scc) begin
      nfail++;
      $display("FAIL %s exec=%h/%h vcc=%h/%h pc=%h/%h scc=%b/%b (actual/expected)",
               tag, exec_mask, m_exec, vcc_mask, m_vcc, pc, m_pc, scc, m_scc);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic [SEL_W-1:0] d,
                      input logic [SEL_W-1:0] s, input logic [PC_W-1:0] tgt,
                      input logic [LANES-1:0] cmp);
    logic [LANES-1:0] n_exec, n_vcc;
    logic             n_scc, taken;
    @(negedge clk);
    issue_valid = v; opcode = op; sdst = d; ssrc = s; br_target = tgt; cmp_result = cmp;
    n_exec = m_exec; n_vcc = m_vcc; n_scc = m_scc; taken = 1'b0;
    if (v) begin
      case (op)
        4'd1: n_vcc = cmp & m_exec;
        4'd3: begin n_exec = m_vcc & m_exec; n_scc = (n_exec != 0); end
        4'd4: begin n_exec = m_slot[s] & ~m_exec; n_scc = (n_exec != 0); end
        4'd5: n_exec = m_slot[s];
        4'd6: taken = (m_vcc == 0);
        4'd7: taken = (m_exec == 0);
        default: ;
      endcase
      if (op == 4'd2) m_slot[d] = m_exec;
    end
    @(posedge clk);
    #1;
    if (v) m_pc = taken ? tgt : m_pc + 1'b1;
    m_exec = n_exec; m_vcc = n_vcc; m_scc = n_scc;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; issue_valid = 1'b1; opcode = 4'd3; cmp_result = 8'h5A; br_target = 16'h1234;
    repeat (3) @(posedge clk);
    #1;
    m_exec = '1; m_vcc = '0; m_pc = '0; m_scc = 1'b0;
    check("R1");
    @(negedge clk);
    rst = 1'b0; issue_valid = 1'b0;
  endtask

  function automatic logic [LANES-1:0] pick_y(input int k, input logic [LANES-1:0] x);
    case (k)
      0: return 8'h00;  1: return 8'hFF;  2: return 8'h01;  3: return 8'h80;
      4: return 8'h0F;  5: return 8'hF0;  6: return 8'h55;  7: return 8'hAA;
      8: return 8'h3C;  9: return 8'hC3;  10: return ~x;   default: return x;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R3: keep an all-ones copy in slot 3
    step(1, 4'd2, 2'd3, '0, '0, '0); check("R3");

    for (int x = 0; x < 256; x++) begin
      for (int k = 0; k < 12; k++) begin
        logic [LANES-1:0] y;
        y = pick_y(k, x[7:0]);
        step(1, 4'd5, '0, 2'd3, '0, '0);     check("R6");
        step(1, 4'd1, '0, '0, '0, x[7:0]);   check("R2");
        step(1, 4'd3, '0, '0, '0, '0);       check("R4");
        step(1, 4'd1, '0, '0, '0, y);        check("R2");
        step(1, 4'd2, 2'd0, '0, '0, '0);     check("R3");
        step(1, 4'd3, '0, '0, '0, '0);       check("R4 R7");
        step(1, 4'd6, '0, '0, 16'h0040, '0); check("R8");
        step(1, 4'd4, '0, 2'd0, '0, '0);     check("R5 R7");
        step(1, 4'd7, '0, '0, 16'h0100, '0); check("R9");
        step(1, 4'd5, '0, 2'd0, '0, '0);     check("R6");
      end
    end

    // R10: idle cycles with busy-looking inputs
    for (int i = 0; i < 16; i++) begin
      step(0, 4'(i), 2'(i), 2'(i), 16'(i * 7), 8'(i * 37)); check("R10");
    end

    // R11: nop and unassigned opcodes
    step(1, 4'd0, '0, '0, 16'hBEEF, 8'hFF); check("R11");
    for (int op = 8; op < 16; op++) begin
      step(1, 4'(op), 2'd1, 2'd1, 16'hBEEF, 8'h00); check("R11");
    end

    // R12: wrap of pc after all ones
    step(1, 4'd1, '0, '0, '0, 8'h00);     check("R2");
    step(1, 4'd6, '0, '0, 16'hFFFF, '0);  check("R8");
    step(1, 4'd0, '0, '0, '0, '0);        check("R12");

    // R1: reset again mid-run
    do_reset();
    step(1, 4'd0, '0, '0, '0, '0); check("R1");

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule